// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the thirty-two-bit general registers of a processor core that runs in seven operating modes. The sixteen architectural register numbers seen by software are folded onto a smaller set of physical registers. Some physical registers are seen by every mode. Others are private copies that only one mode reaches. The current five-bit mode field, together with the register number, picks the physical entry on every access.

Two read ports return data combinationally from the index and mode presented in the same cycle. One write port updates the selected entry at the rising clock edge. Each exception mode also owns a saved status word. The current mode reads this word and can overwrite it.

A privileged handler sometimes needs to save or restore the task's registers. For that, a user-bank override input steers the banked register numbers to the User copies. The program counter logic, the ALU and exception sequencing sit outside and drive this block.

Top module: `banked_regfile`

## Requirements
- R1: Register numbers 0 to 7 address one physical copy each, shared by all modes. A value written in any mode is read back unchanged in every other mode.
- R2: In FIQ mode (10001), numbers 8 to 12 reach copies private to FIQ. Every other mode, including illegal encodings, shares one copy of numbers 8 to 12.
- R3: Numbers 13 and 14 have private copies in each of FIQ, IRQ (10010), Supervisor (10011), Abort (10111) and Undefined (11011). User (10000) and System (11111) share a sixth copy.
- R4: Number 15 is a single register shared by every mode.
- R5: Each of the five exception modes owns one saved status word, written with `spsr_wr_en_i` and read on `spsr_rd_data_o`, with `spsr_valid_o` high. In User or System mode, `spsr_valid_o` is low and `spsr_rd_data_o` reads zero. A saved-status write in those modes changes no stored word.
- R6: Any mode value other than the seven listed encodings raises `mode_illegal_o`. Such a value accesses the User/System copies and has no saved status word. `mode_illegal_o` is low for the seven legal encodings.
- R7: While `user_bank_i` is high, reads and writes of numbers 8 to 14 use the User copies in every mode. Numbers 0 to 7, number 15 and the saved status word are unaffected by the override.
- R8: A read of the entry being written in the same cycle returns the old value. The written value appears from the next cycle.
- R9: After reset, every general register and every saved status word reads zero.
- R10: The two read ports are independent. Each returns, in the same cycle, the entry selected by its own index, and both return the same data when given the same index.
- R11: With `wr_en_i` low, no general register changes, whatever is on the write index and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears all storage |
| mode_i | input | 5 | Current operating mode field |
| user_bank_i | input | 1 | Steer numbers 8 to 14 to the User copies |
| rd_a_idx_i | input | 4 | Register number for read port A |
| rd_a_data_o | output | DATA_W | Read port A data |
| rd_b_idx_i | input | 4 | Register number for read port B |
| rd_b_data_o | output | DATA_W | Read port B data |
| wr_en_i | input | 1 | General register write enable |
| wr_idx_i | input | 4 | Register number to write |
| wr_data_i | input | DATA_W | Write data |
| spsr_wr_en_i | input | 1 | Saved status write enable for the current mode |
| spsr_wr_data_i | input | DATA_W | Saved status write data |
| spsr_rd_data_o | output | DATA_W | Saved status word of the current mode, zero if none |
| spsr_valid_o | output | 1 | Current mode owns a saved status word |
| mode_illegal_o | output | 1 | Mode field holds no legal encoding |

## Verification
The bench builds the block with its default DATA_W of 32. Full-width words are therefore written and compared, and distinct patterns in the upper bits expose any bank aliasing. At this width every one of the 31 physical registers and 5 saved status words falls within random reach. Thousands of writes spread over all legal modes, several illegal encodings and the override input visit every mapping path. Directed sequences place a different value in each bank copy first, so a wrong mapping reads a visibly wrong word.

// File: rtl/banked_regfile_pkg.sv
package banked_regfile_pkg;

    // Architectural view
    localparam int IDX_W       = 4;
    localparam int MODE_W      = 5;
    localparam int N_LOW       = 8;    // numbers below this are shared by all modes
    localparam int N_HI        = 5;    // numbers 8..12, banked only for FIQ
    localparam int FIRST_SP    = N_LOW + N_HI;  // 13: first per-mode pair entry
    localparam int PC_IDX      = (1 << IDX_W) - 1;
    localparam int N_BANKS     = 6;    // user/system, fiq, irq, svc, abt, und

    // Physical layout, derived
    localparam int USR_HI_BASE = N_LOW;
    localparam int FIQ_HI_BASE = USR_HI_BASE + N_HI;
    localparam int PAIR_BASE   = FIQ_HI_BASE + N_HI;
    localparam int PC_SLOT     = PAIR_BASE + 2 * N_BANKS;
    localparam int NUM_PHYS    = PC_SLOT + 1;
    localparam int PHYS_W      = $clog2(NUM_PHYS);
    localparam int NUM_SPSR    = N_BANKS - 1;
    localparam int SPSR_W      = $clog2(NUM_SPSR);

    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011,
        MODE_SYS = 5'b11111
    } cpu_mode_e;

    typedef enum logic [2:0] {
        BANK_USR = 3'd0,
        BANK_FIQ = 3'd1,
        BANK_IRQ = 3'd2,
        BANK_SVC = 3'd3,
        BANK_ABT = 3'd4,
        BANK_UND = 3'd5
    } bank_e;

    typedef struct packed {
        bank_e               bank;
        logic                illegal;
        logic                has_spsr;
        logic [SPSR_W-1:0]   spsr_sel;
    } mode_info_t;

endpackage

// File: rtl/bank_mode_dec.sv
module bank_mode_dec
    import banked_regfile_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output mode_info_t        info_o
);

    always_comb begin
        info_o          = '0;
        info_o.bank     = BANK_USR;
        info_o.illegal  = 1'b0;
        info_o.has_spsr = 1'b1;
        case (mode_i)
            MODE_USR: info_o.has_spsr = 1'b0;
            MODE_SYS: info_o.has_spsr = 1'b0;
            MODE_FIQ: info_o.bank = BANK_FIQ;
            MODE_IRQ: info_o.bank = BANK_IRQ;
            MODE_SVC: info_o.bank = BANK_SVC;
            MODE_ABT: info_o.bank = BANK_ABT;
            MODE_UND: info_o.bank = BANK_UND;
            default: begin
                info_o.illegal  = 1'b1;
                info_o.has_spsr = 1'b0;
            end
        endcase
        // exception banks 1..5 map onto saved status slots 0..4
        if (info_o.has_spsr) begin
            info_o.spsr_sel = SPSR_W'(int'(info_o.bank) - 1);
        end
    end

endmodule

// File: rtl/bank_addr_map.sv
module bank_addr_map
    import banked_regfile_pkg::*;
(
    input  logic [IDX_W-1:0]  idx_i,
    input  bank_e             bank_i,
    input  logic              user_ovr_i,
    output logic [PHYS_W-1:0] phys_o
);

    bank_e eff_bank;
    int    idx_int;

    always_comb begin
        eff_bank = user_ovr_i ? BANK_USR : bank_i;
        idx_int  = int'(idx_i);
        if (idx_int < N_LOW) begin
            phys_o = PHYS_W'(idx_int);
        end else if (idx_int < FIRST_SP) begin
            if (eff_bank == BANK_FIQ) begin
                phys_o = PHYS_W'(FIQ_HI_BASE + idx_int - N_LOW);
            end else begin
                phys_o = PHYS_W'(USR_HI_BASE + idx_int - N_LOW);
            end
        end else if (idx_int == PC_IDX) begin
            phys_o = PHYS_W'(PC_SLOT);
        end else begin
            phys_o = PHYS_W'(PAIR_BASE + 2 * int'(eff_bank) + idx_int - FIRST_SP);
        end
    end

endmodule

// File: rtl/bank_storage.sv
module bank_storage
    import banked_regfile_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHYS_W-1:0] rd_a_phys_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    input  logic [PHYS_W-1:0] rd_b_phys_i,
    output logic [DATA_W-1:0] rd_b_data_o,
    input  logic              wr_en_i,
    input  logic [PHYS_W-1:0] wr_phys_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              spsr_wr_en_i,
    input  logic [SPSR_W-1:0] spsr_sel_i,
    input  logic [DATA_W-1:0] spsr_wr_data_i,
    output logic [DATA_W-1:0] spsr_rd_data_o
);

    localparam logic [PHYS_W-1:0] LAST_PHYS = PHYS_W'(NUM_PHYS - 1);
    localparam logic [SPSR_W-1:0] LAST_SPSR = SPSR_W'(NUM_SPSR - 1);

    typedef struct packed {
        logic [NUM_PHYS-1:0][DATA_W-1:0] regs;
        logic [NUM_SPSR-1:0][DATA_W-1:0] spsr;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i && (wr_phys_i <= LAST_PHYS)) begin
            st_d.regs[wr_phys_i] = wr_data_i;
        end
        if (spsr_wr_en_i && (spsr_sel_i <= LAST_SPSR)) begin
            st_d.spsr[spsr_sel_i] = spsr_wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // reads see the registered state only, so a same-cycle write is not visible
    assign rd_a_data_o    = (rd_a_phys_i <= LAST_PHYS) ? st_q.regs[rd_a_phys_i] : '0;
    assign rd_b_data_o    = (rd_b_phys_i <= LAST_PHYS) ? st_q.regs[rd_b_phys_i] : '0;
    assign spsr_rd_data_o = (spsr_sel_i <= LAST_SPSR) ? st_q.spsr[spsr_sel_i] : '0;

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import banked_regfile_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        mode_i,
    input  logic              user_bank_i,
    input  logic [3:0]        rd_a_idx_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    input  logic [3:0]        rd_b_idx_i,
    output logic [DATA_W-1:0] rd_b_data_o,
    input  logic              wr_en_i,
    input  logic [3:0]        wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              spsr_wr_en_i,
    input  logic [DATA_W-1:0] spsr_wr_data_i,
    output logic [DATA_W-1:0] spsr_rd_data_o,
    output logic              spsr_valid_o,
    output logic              mode_illegal_o
);

    localparam int N_PORTS = 3;   // read A, read B, write

    mode_info_t                         info;
    logic [N_PORTS-1:0][IDX_W-1:0]      port_idx;
    logic [N_PORTS-1:0][PHYS_W-1:0]     port_phys;
    logic [DATA_W-1:0]                  spsr_raw;

    bank_mode_dec u_dec (
        .mode_i (mode_i),
        .info_o (info)
    );

    assign port_idx[0] = rd_a_idx_i;
    assign port_idx[1] = rd_b_idx_i;
    assign port_idx[2] = wr_idx_i;

    for (genvar p = 0; p < N_PORTS; p++) begin : g_map
        bank_addr_map u_map (
            .idx_i      (port_idx[p]),
            .bank_i     (info.bank),
            .user_ovr_i (user_bank_i),
            .phys_o     (port_phys[p])
        );
    end

    bank_storage #(
        .DATA_W (DATA_W)
    ) u_store (
        .clk            (clk),
        .rst_n          (rst_n),
        .rd_a_phys_i    (port_phys[0]),
        .rd_a_data_o    (rd_a_data_o),
        .rd_b_phys_i    (port_phys[1]),
        .rd_b_data_o    (rd_b_data_o),
        .wr_en_i        (wr_en_i),
        .wr_phys_i      (port_phys[2]),
        .wr_data_i      (wr_data_i),
        .spsr_wr_en_i   (spsr_wr_en_i && info.has_spsr),
        .spsr_sel_i     (info.spsr_sel),
        .spsr_wr_data_i (spsr_wr_data_i),
        .spsr_rd_data_o (spsr_raw)
    );

    assign spsr_rd_data_o = info.has_spsr ? spsr_raw : '0;
    assign spsr_valid_o   = info.has_spsr;
    assign mode_illegal_o = info.illegal;

endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
    import banked_regfile_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        mode_i,
    input logic              user_bank_i,
    input logic [3:0]        rd_a_idx_i,
    input logic [DATA_W-1:0] rd_a_data_o,
    input logic [3:0]        rd_b_idx_i,
    input logic [DATA_W-1:0] rd_b_data_o,
    input logic              wr_en_i,
    input logic [3:0]        wr_idx_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              spsr_wr_en_i,
    input logic [DATA_W-1:0] spsr_wr_data_i,
    input logic [DATA_W-1:0] spsr_rd_data_o,
    input logic              spsr_valid_o,
    input logic              mode_illegal_o
);

    logic plain_mode;
    assign plain_mode = (mode_i == MODE_USR) || (mode_i == MODE_SYS);

    assert_low_shared_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> (!($stable(rd_a_idx_i) && (rd_a_idx_i < 4'd8)) || $stable(rd_a_data_o)));

    assert_spsr_none_R5: assert property (@(posedge clk) disable iff (!rst_n)
        plain_mode |-> (!spsr_valid_o && (spsr_rd_data_o == '0)));

    assert_spsr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (spsr_wr_en_i && spsr_valid_o) |=>
            (!$stable(mode_i) || (spsr_rd_data_o == $past(spsr_wr_data_i))));

    assert_illegal_nospsr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_illegal_o |-> !spsr_valid_o);

    assert_write_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (rd_a_idx_i == wr_idx_i)) |=>
            (!($stable(mode_i) && $stable(user_bank_i) && $stable(rd_a_idx_i))
             || (rd_a_data_o == $past(wr_data_i))));

    assert_reset_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((rd_a_data_o == '0) && (rd_b_data_o == '0)));

    assert_ports_agree_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx_i == rd_b_idx_i) |-> (rd_a_data_o == rd_b_data_o));

endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    mode_i = 5'b10000;
    logic          user_bank_i = 1'b0;
    logic [3:0]    rd_a_idx_i = '0;
    logic [DW-1:0] rd_a_data_o;
    logic [3:0]    rd_b_idx_i = '0;
    logic [DW-1:0] rd_b_data_o;
    logic          wr_en_i = 1'b0;
    logic [3:0]    wr_idx_i = '0;
    logic [DW-1:0] wr_data_i = '0;
    logic          spsr_wr_en_i = 1'b0;
    logic [DW-1:0] spsr_wr_data_i = '0;
    logic [DW-1:0] spsr_rd_data_o;
    logic          spsr_valid_o;
    logic          mode_illegal_o;

    int  n_total = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    logic [DW-1:0] m_regs [31];
    logic [DW-1:0] m_spsr [5];

    localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                           M_SVC = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011,
                           M_SYS = 5'b11111;

    always #2 clk = ~clk;

    banked_regfile #(.DATA_W(DW)) u_dut (.*);

    // -------- reference functions written from the requirements --------
    function automatic int bank_of(logic [4:0] m);
        case (m)
            M_FIQ: return 1;
            M_IRQ: return 2;
            M_SVC: return 3;
            M_ABT: return 4;
            M_UND: return 5;
            default: return 0;
        endcase
    endfunction

    function automatic bit legal(logic [4:0] m);
        return (m == M_USR) || (m == M_FIQ) || (m == M_IRQ) || (m == M_SVC)
            || (m == M_ABT) || (m == M_UND) || (m == M_SYS);
    endfunction

    function automatic int slot_of(logic [4:0] m, bit ovr, int idx);
        int b = ovr ? 0 : bank_of(m);
        if (idx < 8) return idx;
        if (idx < 13) return ((b == 1) ? 13 : 8) + idx - 8;
        if (idx == 15) return 30;
        return 18 + 2 * b + idx - 13;
    endfunction

    function automatic logic [DW-1:0] m_read(logic [4:0] m, bit ovr, int idx);
        return m_regs[slot_of(m, ovr, idx)];
    endfunction

    function automatic logic [DW-1:0] m_spsr_read(logic [4:0] m);
        int b = bank_of(m);
        return (b == 0) ? '0 : m_spsr[b-1];
    endfunction

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst_n) begin
            if (wr_en_i) m_regs[slot_of(mode_i, user_bank_i, int'(wr_idx_i))] = wr_data_i;
            if (spsr_wr_en_i && bank_of(mode_i) != 0) m_spsr[bank_of(mode_i)-1] = spsr_wr_data_i;
        end
        @(negedge clk);
    endtask

    task automatic set(logic [4:0] m, bit ovr, int a, int b);
        mode_i = m; user_bank_i = ovr;
        rd_a_idx_i = 4'(a); rd_b_idx_i = 4'(b);
        #1;
    endtask

    task automatic wr(logic [4:0] m, bit ovr, int idx, logic [DW-1:0] d);
        mode_i = m; user_bank_i = ovr;
        wr_en_i = 1'b1; wr_idx_i = 4'(idx); wr_data_i = d;
        tick();
        wr_en_i = 1'b0;
    endtask

    task automatic swr(logic [4:0] m, logic [DW-1:0] d);
        mode_i = m; user_bank_i = 1'b0;
        spsr_wr_en_i = 1'b1; spsr_wr_data_i = d;
        tick();
        spsr_wr_en_i = 1'b0;
    endtask

    initial begin : watchdog
        #(4 * 200000);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin : main
        logic [4:0] modes [7];
        logic [4:0] bad [3];
        logic [DW-1:0] junk;
        modes = '{M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS};
        bad   = '{5'b00000, 5'b10100, 5'b11110};
        for (int i = 0; i < 31; i++) m_regs[i] = '0;
        for (int i = 0; i < 5; i++) m_spsr[i] = '0;
        junk = $urandom(32'h1F2E3D4C);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: everything clears
        for (int i = 0; i < 16; i++) begin
            set(M_USR, 0, i, 15 - i);
            chk("R9 reg zero after reset", rd_a_data_o, '0);
        end
        for (int k = 1; k < 6; k++) begin
            set(modes[k], 0, 0, 0);
            chk("R9 saved status zero after reset", spsr_rd_data_o, '0);
        end

        // R1: low numbers shared
        wr(M_SVC, 0, 3, 32'hA5A5_0003);
        set(M_USR, 0, 3, 3);
        chk("R1 r3 from user", rd_a_data_o, 32'hA5A5_0003);
        set(M_FIQ, 0, 3, 3);
        chk("R1 r3 from fiq", rd_a_data_o, 32'hA5A5_0003);

        // R2: 8..12 banked only for FIQ
        wr(M_USR, 0, 9, 32'h0900_00AA);
        wr(M_FIQ, 0, 9, 32'h0900_00FF);
        set(M_FIQ, 0, 9, 9);
        chk("R2 fiq private r9", rd_a_data_o, 32'h0900_00FF);
        set(M_IRQ, 0, 9, 9);
        chk("R2 irq shares user r9", rd_a_data_o, 32'h0900_00AA);
        set(M_SYS, 0, 9, 9);
        chk("R2 sys shares user r9", rd_a_data_o, 32'h0900_00AA);

        // R3: per-mode r13
        for (int k = 0; k < 6; k++) wr(modes[k], 0, 13, 32'h5100_0000 + DW'(k));
        for (int k = 0; k < 6; k++) begin
            set(modes[k], 0, 13, 14);
            chk("R3 r13 private per mode", rd_a_data_o, 32'h5100_0000 + DW'(k));
        end
        set(M_SYS, 0, 13, 13);
        chk("R3 sys shares user r13", rd_a_data_o, 32'h5100_0000);

        // R4: program counter shared
        wr(M_ABT, 0, 15, 32'h0000_8000);
        set(M_USR, 0, 15, 15);
        chk("R4 pc seen in user", rd_a_data_o, 32'h0000_8000);
        set(M_FIQ, 0, 15, 15);
        chk("R4 pc seen in fiq", rd_a_data_o, 32'h0000_8000);

        // R5: saved status words
        for (int k = 1; k < 6; k++) swr(modes[k], 32'hC000_00C0 + DW'(k));
        for (int k = 1; k < 6; k++) begin
            set(modes[k], 0, 0, 0);
            chk("R5 saved status per mode", spsr_rd_data_o, 32'hC000_00C0 + DW'(k));
            chk("R5 valid in exception mode", 32'(spsr_valid_o), 32'd1);
        end
        swr(M_USR, 32'hDEAD_BEEF);
        set(M_USR, 0, 0, 0);
        chk("R5 user reads zero", spsr_rd_data_o, '0);
        chk("R5 user not valid", 32'(spsr_valid_o), 32'd0);
        for (int k = 1; k < 6; k++) begin
            set(modes[k], 0, 0, 0);
            chk("R5 user write ignored", spsr_rd_data_o, 32'hC000_00C0 + DW'(k));
        end

        // R6: illegal encodings
        set(5'b00000, 0, 13, 13);
        chk("R6 illegal flagged", 32'(mode_illegal_o), 32'd1);
        chk("R6 illegal uses user r13", rd_a_data_o, 32'h5100_0000);
        chk("R6 illegal has no saved status", 32'(spsr_valid_o), 32'd0);
        wr(5'b01010, 0, 14, 32'h1444_0001);
        set(M_USR, 0, 14, 14);
        chk("R6 illegal write lands in user r14", rd_a_data_o, 32'h1444_0001);
        for (int k = 0; k < 7; k++) begin
            set(modes[k], 0, 0, 0);
            chk("R6 legal not flagged", 32'(mode_illegal_o), 32'd0);
        end

        // R7: user-bank override
        set(M_FIQ, 1, 9, 13);
        chk("R7 override r9 from fiq", rd_a_data_o, 32'h0900_00AA);
        chk("R7 override r13 from fiq", rd_b_data_o, 32'h5100_0000);
        wr(M_FIQ, 1, 10, 32'h0A0A_0A0A);
        set(M_USR, 0, 10, 10);
        chk("R7 override write to user r10", rd_a_data_o, 32'h0A0A_0A0A);
        set(M_FIQ, 0, 10, 10);
        chk("R7 fiq r10 untouched", rd_a_data_o, 32'h0);
        set(M_SVC, 1, 3, 15);
        chk("R7 override leaves r3", rd_a_data_o, 32'hA5A5_0003);
        chk("R7 override leaves pc", rd_b_data_o, 32'h0000_8000);
        chk("R7 override leaves saved status", spsr_rd_data_o, 32'hC000_00C3);

        // R8: read during write
        set(M_SVC, 0, 5, 5);
        wr_en_i = 1'b1; wr_idx_i = 4'd5; wr_data_i = 32'h5555_1234;
        #1;
        chk("R8 old value during write", rd_a_data_o, 32'h0);
        tick();
        wr_en_i = 1'b0;
        #1;
        chk("R8 new value next cycle", rd_a_data_o, 32'h5555_1234);

        // R11: disabled write
        wr_idx_i = 4'd5; wr_data_i = 32'hFFFF_FFFF;
        tick();
        set(M_SVC, 0, 5, 3);
        chk("R11 no write when disabled", rd_a_data_o, 32'h5555_1234);

        // R10: independent ports
        chk("R10 port b independent", rd_b_data_o, 32'hA5A5_0003);

        // Random mix against the model
        for (int n = 0; n < 4000; n++) begin
            logic [4:0] m;
            int r = int'($urandom_range(0, 99));
            m = (r < 8) ? bad[$urandom_range(0, 2)] : modes[$urandom_range(0, 6)];
            mode_i         = m;
            user_bank_i    = ($urandom_range(0, 3) == 0);
            rd_a_idx_i     = 4'($urandom_range(0, 15));
            rd_b_idx_i     = 4'($urandom_range(0, 15));
            wr_en_i        = ($urandom_range(0, 1) == 1);
            wr_idx_i       = 4'($urandom_range(0, 15));
            wr_data_i      = $urandom;
            spsr_wr_en_i   = ($urandom_range(0, 4) == 0);
            spsr_wr_data_i = $urandom;
            #1;
            chk("R10 random port a", rd_a_data_o, m_read(m, user_bank_i, int'(rd_a_idx_i)));
            chk("R10 random port b", rd_b_data_o, m_read(m, user_bank_i, int'(rd_b_idx_i)));
            chk("R5 random saved status", spsr_rd_data_o, m_spsr_read(m));
            chk("R6 random illegal flag", 32'(mode_illegal_o), 32'(!legal(m)));
            tick();
        end
        wr_en_i = 1'b0; spsr_wr_en_i = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule